// File: doc/BRIEF.md
# Multiprocessor Receive Address Filter

This block sits after the byte assembler of a 9-bit multiprocessor serial receiver. It decides whether a completed byte should set the receiver's interrupt flag. Software programs two registers: a node address and an address mask. While filtering is active, a byte raises the flag only when it matches this node. A byte can match in two ways. It can be an individual address, where the bits selected by the mask equal the node address. It can be a broadcast, where every bit of the pattern (node address OR mask) is also set in the byte. When the serial mode is zero, or multiprocessor operation is disabled, every completed byte raises the flag.

Each strobed byte is judged by a small state machine. It has three states. ST_WAIT means no byte was seen in the previous cycle. ST_TAKE means the previous byte was accepted, and this state drives the flag-set pulse. ST_DROP means the previous byte was rejected. Every state moves to ST_TAKE on a strobe the filter accepts, to ST_DROP on a strobe it rejects, and to ST_WAIT when there is no strobe. The flag-set output is therefore a one-cycle pulse registered one clock after the strobe. Back-to-back accepted bytes give back-to-back pulses.

Top module: `mpaf_top`

## Requirements
- R1: After reset the node-address and mask registers both hold zero, and the flag-set output is low.
- R2: With a serial mode value of 0, every strobed byte causes a flag-set pulse, whatever the register contents.
- R3: With multiprocessor enable low, every strobed byte causes a flag-set pulse, whatever the register contents.
- R4: While filtering is active (mode non-zero and enable high), a byte B is accepted when (address AND mask) equals (B AND mask).
- R5: While filtering is active, a byte B is accepted when every bit set in (address OR mask) is also set in B.
- R6: While filtering is active, a byte matching neither rule produces no flag-set pulse.
- R7: With a mask of zero, every byte is accepted, so the filter is transparent.
- R8: rx_flag_set goes high for exactly the one cycle after an accepted rx_vld cycle, and it is low in the cycle after any cycle without rx_vld.
- R9: A write strobe (cfg_addr_we or cfg_mask_we) loads cfg_wdata into its register at the clock edge. The new value governs bytes strobed from the following cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr_we | input | 1 | Load node-address register from cfg_wdata |
| cfg_mask_we | input | 1 | Load mask register from cfg_wdata |
| cfg_wdata | input | 8 | Register write data |
| ser_mode | input | 2 | Serial mode; 0 disables filtering |
| mp_enable | input | 1 | Multiprocessor enable; 0 disables filtering |
| rx_vld | input | 1 | One-cycle strobe: rx_data holds a completed byte |
| rx_data | input | 8 | Received byte |
| rx_flag_set | output | 1 | Pulse to set the receive flag, one cycle after an accepted strobe |

## Verification
The assertions assume that ser_mode, mp_enable and the registers are stable in the strobe cycle they judge. They also assume that rx_vld may be high in consecutive cycles. The bench changes inputs only between edges and samples away from them. It mixes bursts of strobes with idle gaps and with register writes in the same cycle as a strobe. This exercises the back-to-back paths and the write-ordering rule. The bench steers bytes toward individual-only, broadcast-only and no-match cases as well as random sweeps, so that each acceptance path is exercised on its own.

// File: rtl/mpaf_pkg.sv
package mpaf_pkg;
    localparam int BYTE_W = 8;
    localparam int MODE_W = 2;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_TAKE = 2'd1,
        ST_DROP = 2'd2
    } filt_state_t;
endpackage

// File: rtl/mpaf_regs.sv
module mpaf_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         addr_we,
    input  logic         mask_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] addr_q,
    output logic [W-1:0] mask_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            mask_q <= '0;
        end else begin
            if (addr_we) addr_q <= wdata;
            if (mask_we) mask_q <= wdata;
        end
    end
endmodule

// File: rtl/mpaf_match.sv
module mpaf_match #(
    parameter int W  = 8,
    parameter int MW = 2
) (
    input  logic [W-1:0]  addr_q,
    input  logic [W-1:0]  mask_q,
    input  logic [W-1:0]  data,
    input  logic [MW-1:0] mode,
    input  logic          mp_en,
    output logic          accept
);
    logic [W-1:0] bc_pat;
    logic         ind_hit;
    logic         bc_hit;
    logic         filter_on;

    always_comb begin
        bc_pat    = addr_q | mask_q;
        ind_hit   = ((addr_q ^ data) & mask_q) == '0;
        bc_hit    = (bc_pat & ~data) == '0;
        filter_on = (mode != '0) && mp_en;
        accept    = !filter_on || ind_hit || bc_hit;
    end
endmodule

// File: rtl/mpaf_fsm.sv
module mpaf_fsm
    import mpaf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vld,
    input  logic accept,
    output logic flag_set
);
    filt_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        if (!vld)        state_d = ST_WAIT;
        else if (accept) state_d = ST_TAKE;
        else             state_d = ST_DROP;
    end

    always_comb begin
        unique case (state_q)
            ST_WAIT: flag_set = 1'b0;
            ST_TAKE: flag_set = 1'b1;
            ST_DROP: flag_set = 1'b0;
            default: flag_set = 1'b0;
        endcase
    end
endmodule

// File: rtl/mpaf_top.sv
module mpaf_top
    import mpaf_pkg::*;
#(
    parameter int DATA_W = BYTE_W,
    parameter int SMODE_W = MODE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_addr_we,
    input  logic               cfg_mask_we,
    input  logic [DATA_W-1:0]  cfg_wdata,
    input  logic [SMODE_W-1:0] ser_mode,
    input  logic               mp_enable,
    input  logic               rx_vld,
    input  logic [DATA_W-1:0]  rx_data,
    output logic               rx_flag_set
);
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] mask_q;
    logic              accept;

    mpaf_regs #(.W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_we (cfg_addr_we),
        .mask_we (cfg_mask_we),
        .wdata   (cfg_wdata),
        .addr_q  (addr_q),
        .mask_q  (mask_q)
    );

    mpaf_match #(.W(DATA_W), .MW(SMODE_W)) u_match (
        .addr_q (addr_q),
        .mask_q (mask_q),
        .data   (rx_data),
        .mode   (ser_mode),
        .mp_en  (mp_enable),
        .accept (accept)
    );

    mpaf_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld      (rx_vld),
        .accept   (accept),
        .flag_set (rx_flag_set)
    );
endmodule

// File: rtl/mpaf_checker.sv
module mpaf_checker #(
    parameter int DATA_W = 8,
    parameter int SMODE_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [SMODE_W-1:0] ser_mode,
    input logic               mp_enable,
    input logic               rx_vld,
    input logic [DATA_W-1:0]  rx_data,
    input logic [DATA_W-1:0]  addr_q,
    input logic [DATA_W-1:0]  mask_q,
    input logic               rx_flag_set
);
    logic filt_active;
    logic no_hit;
    assign filt_active = (ser_mode != '0) && mp_enable;
    assign no_hit = ((addr_q & mask_q) != (rx_data & mask_q)) &&
                    (((addr_q | mask_q) & rx_data) != (addr_q | mask_q));

    always_comb begin
        if (!rst_n) begin
            p_reset_regs_r1: assert (addr_q == '0 && mask_q == '0 && !rx_flag_set);
        end
    end

    p_mode0_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && ser_mode == '0) |=> rx_flag_set);

    p_mpoff_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && !mp_enable) |=> rx_flag_set);

    p_nohit_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && filt_active && no_hit) |=> !rx_flag_set);

    p_zero_mask_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && mask_q == '0) |=> rx_flag_set);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_vld |=> !rx_flag_set);
endmodule

bind mpaf_top mpaf_checker #(.DATA_W(DATA_W), .SMODE_W(SMODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_mode    (ser_mode),
    .mp_enable   (mp_enable),
    .rx_vld      (rx_vld),
    .rx_data     (rx_data),
    .addr_q      (addr_q),
    .mask_q      (mask_q),
    .rx_flag_set (rx_flag_set)
);

// File: tb/tb_mpaf_top.sv
module tb_mpaf_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_addr_we = 1'b0;
    logic       cfg_mask_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [1:0] ser_mode = '0;
    logic       mp_enable = 1'b0;
    logic       rx_vld = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_flag_set;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Reference register copies and pending expectation
    bit [7:0] ref_addr = '0;
    bit [7:0] ref_mask = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpaf_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_addr_we (cfg_addr_we),
        .cfg_mask_we (cfg_mask_we),
        .cfg_wdata   (cfg_wdata),
        .ser_mode    (ser_mode),
        .mp_enable   (mp_enable),
        .rx_vld      (rx_vld),
        .rx_data     (rx_data),
        .rx_flag_set (rx_flag_set)
    );

    function automatic bit ref_accept(bit [7:0] a, bit [7:0] m, bit [7:0] b,
                                      bit [1:0] md, bit en);
        bit ind, bc;
        if (md == 0 || !en) return 1'b1;
        ind = (a & m) == (b & m);
        bc  = ((a | m) & b) == (a | m);
        return ind || bc;
    endfunction

    task automatic check(input bit act, input bit exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: rx_flag_set=%0b expected %0b (byte %02h addr %02h mask %02h)",
                     req, act, exp, rx_data, ref_addr, ref_mask);
        end
    endtask

    // One clock: apply inputs, clock, compare output against reference
    task automatic step(input bit v, input bit [7:0] d, input bit aw, input bit mw,
                        input bit [7:0] wd, input string req);
        bit exp;
        rx_vld = v; rx_data = d;
        cfg_addr_we = aw; cfg_mask_we = mw; cfg_wdata = wd;
        exp = v && ref_accept(ref_addr, ref_mask, d, ser_mode, mp_enable);
        @(posedge clk);
        if (aw) ref_addr = wd;
        if (mw) ref_mask = wd;
        #1;
        check(rx_flag_set, exp, req);
        @(negedge clk);
        rx_vld = 0; cfg_addr_we = 0; cfg_mask_we = 0;
    endtask

    task automatic wr(input bit [7:0] a, input bit [7:0] m);
        step(0, 8'h00, 1, 0, a, "R9");
        step(0, 8'h00, 0, 1, m, "R9");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(rx_flag_set, 1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check(rx_flag_set, 1'b0, "R1");
        ser_mode = 2'd1; mp_enable = 1'b1;
        // R1/R7: zero registers accept arbitrary byte while filtering
        step(1, 8'h5A, 0, 0, 0, "R1");
        step(1, 8'hC3, 0, 0, 0, "R7");
        step(0, 8'hFF, 0, 0, 0, "R8");

        // Address 0x23, mask 0xF0: individual key 0x20, broadcast pattern 0xF3
        wr(8'h23, 8'hF0);
        step(1, 8'h2F, 0, 0, 0, "R4");   // individual only
        step(1, 8'h21, 0, 0, 0, "R4");
        step(1, 8'hF3, 0, 0, 0, "R5");   // broadcast only
        step(1, 8'hFF, 0, 0, 0, "R5");
        step(1, 8'h15, 0, 0, 0, "R6");   // no match
        step(1, 8'hE3, 0, 0, 0, "R6");
        step(1, 8'h2A, 0, 0, 0, "R8");   // back-to-back accept
        step(0, 8'h2A, 0, 0, 0, "R8");

        // R2: mode zero passes everything
        ser_mode = 2'd0;
        step(1, 8'h15, 0, 0, 0, "R2");
        step(1, 8'h00, 0, 0, 0, "R2");
        // R3: enable low passes everything
        ser_mode = 2'd3; mp_enable = 1'b0;
        step(1, 8'h15, 0, 0, 0, "R3");
        mp_enable = 1'b1;
        step(1, 8'h15, 0, 0, 0, "R6");

        // R9: write in same cycle as byte uses old value, new value next
        step(1, 8'h15, 0, 1, 8'h00, "R9"); // old mask rejects
        step(1, 8'h15, 0, 0, 0, "R9");     // now mask 0 -> accept (R7)
        step(1, 8'h15, 0, 1, 8'hF0, "R7");
        step(1, 8'h15, 0, 0, 0, "R9");

        // Random sweep across modes and registers, tagged by path
        for (int i = 0; i < 400; i++) begin
            bit [7:0] b;
            string tag;
            if (i % 50 == 0) wr(8'($urandom), 8'($urandom));
            ser_mode  = 2'($urandom);
            mp_enable = ($urandom % 4) != 0;
            b = 8'($urandom);
            if (i % 3 == 0) b = (ref_addr & ref_mask) | (b & ~ref_mask);
            if (ser_mode == 0) tag = "R2";
            else if (!mp_enable) tag = "R3";
            else if ((ref_addr & ref_mask) == (b & ref_mask)) tag = "R4";
            else if (((ref_addr | ref_mask) & b) == (ref_addr | ref_mask)) tag = "R5";
            else tag = "R6";
            step(($urandom % 5) != 0, b, 0, 0, 0, tag);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule